// File: doc/BRIEF.md
# Iterative Multiply/Divide Unit with HI/LO Result Registers

This block performs 32-bit integer multiplication and division over many clock cycles. It keeps its results in two private registers, HI and LO, instead of a general destination register. A start command carries two operands and a 2-bit operation code. The unit accepts it only while idle, then runs a radix-2 loop: shift-and-add for products, restoring subtraction for quotients. It raises `busy` until the result has been written. Software-visible transfers are move-to (load HI and/or LO from `mt_data`) and move-from (read HI or LO on `rd_data`). A move-from request made while the unit is busy raises `stall` until the result is in place.

The controller is a three-state machine. IDLE goes to RUN on an accepted start and otherwise stays in IDLE. RUN performs one iteration per cycle and goes to FIX after its W-th iteration; before that it stays in RUN. FIX applies the sign correction and the divide-by-zero pattern, writes HI and LO, and always returns to IDLE. `busy` is high in RUN and FIX.

Top module: `muldiv_hilo`

## Requirements
- R1: With `op` = 2'b00 (signed) or 2'b01 (unsigned), the full 64-bit product is formed. Its upper half is written to HI and its lower half to LO. No overflow is ever signalled.
- R2: With `op` = 2'b10 (signed) or 2'b11 (unsigned), LO receives the quotient and HI the remainder. Signed quotients truncate toward zero and the remainder carries the dividend's sign. 0x80000000 divided by -1 gives quotient 0x80000000 and remainder 0.
- R3: A divisor of zero, signed or unsigned, completes normally with LO = 0xFFFFFFFF and HI = the dividend unchanged.
- R4: `busy` rises in the cycle after an accepted start and stays high for exactly 33 cycles. HI and LO keep their previous values while `busy` is high, and they hold the new result in the first cycle in which `busy` is low.
- R5: A `start` asserted while `busy` is high is ignored: the running operation and its result are unaffected.
- R6: While idle and with `start` low, `mt_hi` and/or `mt_lo` load HI and/or LO from `mt_data` at the clock edge, and both may be set together. Move-to requests are ignored while busy or when `start` is high in the same cycle.
- R7: `rd_data` shows HI when `rd_sel_hi` = 1 and LO when it is 0, taken from the current register contents with no clock delay.
- R8: `stall` is high exactly when `rd_req` is high while `busy` is high. It is low whenever the unit is idle.
- R9: After reset, HI = LO = 0, `busy` = 0 and `stall` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (taken only while idle) |
| op | input | 2 | 00 signed mul, 01 unsigned mul, 10 signed div, 11 unsigned div |
| opa | input | 32 | Multiplicand / dividend |
| opb | input | 32 | Multiplier / divisor |
| mt_hi | input | 1 | Load HI from `mt_data` |
| mt_lo | input | 1 | Load LO from `mt_data` |
| mt_data | input | 32 | Value for move-to |
| rd_req | input | 1 | Move-from request (drives `stall` while busy) |
| rd_sel_hi | input | 1 | 1 selects HI, 0 selects LO on `rd_data` |
| rd_data | output | 32 | Selected HI or LO value |
| busy | output | 1 | Operation in progress |
| stall | output | 1 | Move-from must wait |

## Verification
Two functions can land in the same cycle: a start command together with a move-to request while the unit is idle. The bench provokes this by raising `start`, `mt_hi` and `mt_lo` on one edge with a distinctive `mt_data`. The command must win: once `busy` falls, HI and LO must hold the division result and not the move-to value. A second overlap is provoked while the unit is running. A move-from request, a fresh start and a move-to are all issued mid-operation. `stall` must be high and the old HI must remain readable, and after completion the first operation's result must be intact.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [1:0] {
        OP_MULS = 2'b00,
        OP_MULU = 2'b01,
        OP_DIVS = 2'b10,
        OP_DIVU = 2'b11
    } md_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } md_state_e;

endpackage

// File: rtl/muldiv_mul_core.sv
module muldiv_mul_core #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           step,
    input  logic [W-1:0]   mcand_in,
    input  logic [W-1:0]   mplier_in,
    output logic [2*W-1:0] prod
);

    logic [W-1:0]   mcand_q;
    logic [2*W-1:0] acc_q;
    logic [W:0]     partial;

    // add the multiplicand into the upper half when the current multiplier bit is set
    always_comb begin
        partial = {1'b0, acc_q[2*W-1:W]} + (acc_q[0] ? {1'b0, mcand_q} : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcand_q <= '0;
            acc_q   <= '0;
        end else if (load) begin
            mcand_q <= mcand_in;
            acc_q   <= {{W{1'b0}}, mplier_in};
        end else if (step) begin
            acc_q   <= {partial, acc_q[W-1:1]};
        end
    end

    assign prod = acc_q;

endmodule

// File: rtl/muldiv_div_core.sv
module muldiv_div_core #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] dividend_in,
    input  logic [W-1:0] divisor_in,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem
);

    logic [W-1:0] dsr_q;
    logic [W-1:0] rem_q;
    logic [W-1:0] quo_q;
    logic [W:0]   trial;
    logic [W-1:0] shifted;

    // trial subtraction of the divisor from the remainder with the next dividend bit shifted in
    always_comb begin
        trial   = {rem_q, quo_q[W-1]} - {1'b0, dsr_q};
        shifted = {rem_q[W-2:0], quo_q[W-1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dsr_q <= '0;
            rem_q <= '0;
            quo_q <= '0;
        end else if (load) begin
            dsr_q <= divisor_in;
            rem_q <= '0;
            quo_q <= dividend_in;
        end else if (step) begin
            if (!trial[W]) begin
                rem_q <= trial[W-1:0];
                quo_q <= {quo_q[W-2:0], 1'b1};
            end else begin
                rem_q <= shifted;
                quo_q <= {quo_q[W-2:0], 1'b0};
            end
        end
    end

    assign quot = quo_q;
    assign rem  = rem_q;

endmodule

// File: rtl/muldiv_ctrl.sv
module muldiv_ctrl
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic accept,
    output logic step,
    output logic finish,
    output logic busy
);

    localparam int CW = $clog2(W);

    md_state_e     state_q;
    md_state_e     state_d;
    logic [CW-1:0] iter_q;
    logic          last_iter;

    assign last_iter = (iter_q == CW'(W - 1));

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)     state_d = ST_RUN;
            ST_RUN:  if (last_iter) state_d = ST_FIX;
            ST_FIX:                 state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // iteration counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      iter_q <= '0;
        else if (accept) iter_q <= '0;
        else if (step)   iter_q <= iter_q + 1'b1;
    end

    // outputs
    always_comb begin
        accept = 1'b0;
        step   = 1'b0;
        finish = 1'b0;
        busy   = 1'b0;
        unique case (state_q)
            ST_IDLE: accept = start;
            ST_RUN: begin
                step = 1'b1;
                busy = 1'b1;
            end
            ST_FIX: begin
                finish = 1'b1;
                busy   = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/muldiv_hilo.sv
module muldiv_hilo
    import muldiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [1:0]   op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         mt_hi,
    input  logic         mt_lo,
    input  logic [W-1:0] mt_data,
    input  logic         rd_req,
    input  logic         rd_sel_hi,
    output logic [W-1:0] rd_data,
    output logic         busy,
    output logic         stall
);

    logic           accept;
    logic           step;
    logic           finish;
    md_op_e         op_in;
    logic           signed_op;
    logic           a_neg;
    logic           b_neg;
    logic [W-1:0]   a_mag;
    logic [W-1:0]   b_mag;

    md_op_e         op_q;
    logic           res_neg_q;
    logic           rem_neg_q;
    logic           div_zero_q;
    logic [W-1:0]   dividend_q;

    logic [2*W-1:0] prod;
    logic [W-1:0]   quot;
    logic [W-1:0]   rem;
    logic [2*W-1:0] prod_fix;
    logic [W-1:0]   quot_fix;
    logic [W-1:0]   rem_fix;
    logic [W-1:0]   hi_new;
    logic [W-1:0]   lo_new;
    logic [W-1:0]   hi_q;
    logic [W-1:0]   lo_q;
    logic           mt_ok;

    muldiv_ctrl #(.W(W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .accept (accept),
        .step   (step),
        .finish (finish),
        .busy   (busy)
    );

    // operand magnitudes for the unsigned iterative cores
    always_comb begin
        op_in     = md_op_e'(op);
        signed_op = (op_in == OP_MULS) || (op_in == OP_DIVS);
        a_neg     = signed_op && opa[W-1];
        b_neg     = signed_op && opb[W-1];
        a_mag     = a_neg ? (~opa + 1'b1) : opa;
        b_mag     = b_neg ? (~opb + 1'b1) : opb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q       <= OP_MULS;
            res_neg_q  <= 1'b0;
            rem_neg_q  <= 1'b0;
            div_zero_q <= 1'b0;
            dividend_q <= '0;
        end else if (accept) begin
            op_q       <= op_in;
            res_neg_q  <= a_neg ^ b_neg;
            rem_neg_q  <= a_neg;
            div_zero_q <= (opb == '0);
            dividend_q <= opa;
        end
    end

    muldiv_mul_core #(.W(W)) u_mul (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .step      (step),
        .mcand_in  (a_mag),
        .mplier_in (b_mag),
        .prod      (prod)
    );

    muldiv_div_core #(.W(W)) u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (accept),
        .step        (step),
        .dividend_in (a_mag),
        .divisor_in  (b_mag),
        .quot        (quot),
        .rem         (rem)
    );

    // sign restoration and the zero-divisor pattern
    always_comb begin
        prod_fix = res_neg_q ? (~prod + 1'b1) : prod;
        quot_fix = res_neg_q ? (~quot + 1'b1) : quot;
        rem_fix  = rem_neg_q ? (~rem + 1'b1) : rem;
        if ((op_q == OP_MULS) || (op_q == OP_MULU)) begin
            hi_new = prod_fix[2*W-1:W];
            lo_new = prod_fix[W-1:0];
        end else if (div_zero_q) begin
            hi_new = dividend_q;
            lo_new = '1;
        end else begin
            hi_new = rem_fix;
            lo_new = quot_fix;
        end
    end

    assign mt_ok = !busy && !start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (finish) begin
            hi_q <= hi_new;
            lo_q <= lo_new;
        end else if (mt_ok) begin
            if (mt_hi) hi_q <= mt_data;
            if (mt_lo) lo_q <= mt_data;
        end
    end

    assign rd_data = rd_sel_hi ? hi_q : lo_q;
    assign stall   = rd_req && busy;

endmodule

// File: rtl/muldiv_hilo_chk.sv
module muldiv_hilo_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [1:0]   op,
    input logic [W-1:0] opa,
    input logic [W-1:0] opb,
    input logic         mt_hi,
    input logic [W-1:0] mt_data,
    input logic         rd_req,
    input logic         busy,
    input logic         stall,
    input logic [W-1:0] hi_q,
    input logic [W-1:0] lo_q,
    input logic [1:0]   op_q
);

    localparam int BW = $clog2(W + 2) + 1;

    logic [BW-1:0]  busy_cnt;
    logic [W-1:0]   cap_a;
    logic [W-1:0]   cap_b;
    logic [1:0]     cap_op;
    logic [2*W-1:0] umul;
    logic [2*W-1:0] smul;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_cnt <= '0;
            cap_a    <= '0;
            cap_b    <= '0;
            cap_op   <= '0;
        end else begin
            busy_cnt <= busy ? busy_cnt + 1'b1 : '0;
            if (start && !busy) begin
                cap_a  <= opa;
                cap_b  <= opb;
                cap_op <= op;
            end
        end
    end

    always_comb begin
        umul = {{W{1'b0}}, cap_a} * {{W{1'b0}}, cap_b};
        smul = {{W{cap_a[W-1]}}, cap_a} * {{W{cap_b[W-1]}}, cap_b};
    end

    a_r1_unsigned_product: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && cap_op == 2'b01) |-> ({hi_q, lo_q} == umul));

    a_r1_signed_product: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && cap_op == 2'b00) |-> ({hi_q, lo_q} == smul));

    a_r2_unsigned_quotient: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && cap_op == 2'b11 && cap_b != '0) |->
        (lo_q == cap_a / cap_b && hi_q == cap_a % cap_b));

    a_r3_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && cap_op[1] && cap_b == '0) |-> (lo_q == '1 && hi_q == cap_a));

    a_r4_busy_length: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_cnt == BW'(W + 1)));

    a_r4_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || ($stable(hi_q) && $stable(lo_q))));

    a_r5_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(op_q));

    a_r6_move_to_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start && mt_hi) |=> (hi_q == $past(mt_data)));

    a_r8_stall_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && busy) |-> stall);

    a_r8_no_stall_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !stall);

endmodule

bind muldiv_hilo muldiv_hilo_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .op      (op),
    .opa     (opa),
    .opb     (opb),
    .mt_hi   (mt_hi),
    .mt_data (mt_data),
    .rd_req  (rd_req),
    .busy    (busy),
    .stall   (stall),
    .hi_q    (hi_q),
    .lo_q    (lo_q),
    .op_q    (op_q)
);

// File: tb/muldiv_hilo_test.sv
module muldiv_hilo_test;

    localparam int W     = 32;
    localparam int NVEC  = 22;
    localparam int LAT   = W + 1;

    // entry layout: {op, opa, opb, expected HI, expected LO}
    localparam logic [129:0] VEC [NVEC] = '{
        {2'd1, 32'h00000003, 32'h00000005, 32'h00000000, 32'h0000000F},
        {2'd1, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFE, 32'h00000001},
        {2'd1, 32'h80000000, 32'h00000002, 32'h00000001, 32'h00000000},
        {2'd1, 32'h00000000, 32'h12345678, 32'h00000000, 32'h00000000},
        {2'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 32'h00000001},
        {2'd0, 32'hFFFFFFFE, 32'h00000003, 32'hFFFFFFFF, 32'hFFFFFFFA},
        {2'd0, 32'h00000007, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFF9},
        {2'd0, 32'h80000000, 32'h80000000, 32'h40000000, 32'h00000000},
        {2'd0, 32'h00010000, 32'h00010000, 32'h00000001, 32'h00000000},
        {2'd2, 32'h00000007, 32'h00000002, 32'h00000001, 32'h00000003},
        {2'd2, 32'hFFFFFFF9, 32'h00000002, 32'hFFFFFFFF, 32'hFFFFFFFD},
        {2'd2, 32'h00000007, 32'hFFFFFFFE, 32'h00000001, 32'hFFFFFFFD},
        {2'd2, 32'hFFFFFFF9, 32'hFFFFFFFE, 32'hFFFFFFFF, 32'h00000003},
        {2'd2, 32'h80000000, 32'hFFFFFFFF, 32'h00000000, 32'h80000000},
        {2'd2, 32'h80000000, 32'h00000001, 32'h00000000, 32'h80000000},
        {2'd2, 32'hFFFFFFFB, 32'h00000007, 32'hFFFFFFFB, 32'h00000000},
        {2'd2, 32'hFFFFFFF9, 32'h00000000, 32'hFFFFFFF9, 32'hFFFFFFFF},
        {2'd3, 32'h00000064, 32'h00000007, 32'h00000002, 32'h0000000E},
        {2'd3, 32'hFFFFFFFF, 32'hFFFFFFFE, 32'h00000001, 32'h00000001},
        {2'd3, 32'h80000000, 32'hFFFFFFFF, 32'h80000000, 32'h00000000},
        {2'd3, 32'h00001234, 32'h00000000, 32'h00001234, 32'hFFFFFFFF},
        {2'd3, 32'h00000000, 32'h00000005, 32'h00000000, 32'h00000000}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [1:0]   op = 2'd0;
    logic [W-1:0] opa = '0;
    logic [W-1:0] opb = '0;
    logic         mt_hi = 1'b0;
    logic         mt_lo = 1'b0;
    logic [W-1:0] mt_data = '0;
    logic         rd_req = 1'b0;
    logic         rd_sel_hi = 1'b0;
    logic [W-1:0] rd_data;
    logic         busy;
    logic         stall;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    muldiv_hilo #(.W(W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op        (op),
        .opa       (opa),
        .opb       (opb),
        .mt_hi     (mt_hi),
        .mt_lo     (mt_lo),
        .mt_data   (mt_data),
        .rd_req    (rd_req),
        .rd_sel_hi (rd_sel_hi),
        .rd_data   (rd_data),
        .busy      (busy),
        .stall     (stall)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic read_reg(input logic sel_hi, output logic [W-1:0] val);
        rd_sel_hi = sel_hi;
        #1;
        val = rd_data;
    endtask

    // waits at falling edges until busy drops, returns the number of busy cycles seen
    task automatic wait_idle(output int cyc);
        cyc = 0;
        while (busy && cyc < 1000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic run_op(input logic [1:0] o, input logic [W-1:0] a, input logic [W-1:0] b,
                          output int cyc);
        op    = o;
        opa   = a;
        opb   = b;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle(cyc);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [W-1:0] v;
        int           cyc;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset state, R7 read path, R8 no stall when idle
        check("R9 busy after reset", {31'b0, busy}, 32'd0);
        rd_req = 1'b1;
        #1;
        check("R8 stall idle", {31'b0, stall}, 32'd0);
        read_reg(1'b1, v);
        check("R9 HI after reset", v, 32'd0);
        read_reg(1'b0, v);
        check("R9 LO after reset", v, 32'd0);
        rd_req = 1'b0;
        @(negedge clk);

        // vector table: R1 multiply, R2 divide, R3 zero divisor, R4 latency
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0]   vo;
            logic [W-1:0] va, vb, ehi, elo;
            string        tag;
            {vo, va, vb, ehi, elo} = VEC[i];
            if (!vo[1])          tag = $sformatf("R1 vec %0d", i);
            else if (vb == '0)   tag = $sformatf("R3 vec %0d", i);
            else                 tag = $sformatf("R2 vec %0d", i);
            run_op(vo, va, vb, cyc);
            check($sformatf("R4 busy cycles vec %0d", i), 32'(cyc), 32'(LAT));
            read_reg(1'b1, v);
            check({tag, " HI"}, v, ehi);
            read_reg(1'b0, v);
            check({tag, " LO"}, v, elo);
            @(negedge clk);
        end

        // R6 move-to, separately and together
        mt_data = 32'hA5A5_0001;
        mt_hi   = 1'b1;
        @(negedge clk);
        mt_hi   = 1'b0;
        mt_data = 32'h5A5A_0002;
        mt_lo   = 1'b1;
        @(negedge clk);
        mt_lo   = 1'b0;
        read_reg(1'b1, v);
        check("R6 move-to HI", v, 32'hA5A5_0001);
        read_reg(1'b0, v);
        check("R6 move-to LO", v, 32'h5A5A_0002);
        mt_data = 32'h1111_1111;
        mt_hi   = 1'b1;
        mt_lo   = 1'b1;
        @(negedge clk);
        mt_hi   = 1'b0;
        mt_lo   = 1'b0;
        read_reg(1'b1, v);
        check("R6 move-to both HI", v, 32'h1111_1111);
        read_reg(1'b0, v);
        check("R6 move-to both LO", v, 32'h1111_1111);

        // R8 stall, R4 hold, R5 start ignored, R6 move-to ignored while busy
        op    = 2'd1;
        opa   = 32'd2;
        opb   = 32'd3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        rd_req = 1'b1;
        read_reg(1'b1, v);
        check("R8 stall while busy", {31'b0, stall}, 32'd1);
        check("R4 HI held while busy", v, 32'h1111_1111);
        op      = 2'd1;
        opa     = 32'd7;
        opb     = 32'd9;
        start   = 1'b1;
        mt_data = 32'hDEAD_BEEF;
        mt_hi   = 1'b1;
        mt_lo   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        mt_hi   = 1'b0;
        mt_lo   = 1'b0;
        read_reg(1'b0, v);
        check("R6 move-to ignored while busy", v, 32'h1111_1111);
        wait_idle(cyc);
        #1;
        check("R8 stall released at completion", {31'b0, stall}, 32'd0);
        read_reg(1'b0, v);
        check("R5 second start ignored LO", v, 32'd6);
        read_reg(1'b1, v);
        check("R5 second start ignored HI", v, 32'd0);
        rd_req = 1'b0;
        @(negedge clk);
        check("R5 no second run", {31'b0, busy}, 32'd0);

        // R6 start and move-to in the same idle cycle: start wins
        op      = 2'd3;
        opa     = 32'd100;
        opb     = 32'd7;
        mt_data = 32'hCAFE_F00D;
        mt_hi   = 1'b1;
        mt_lo   = 1'b1;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        mt_hi   = 1'b0;
        mt_lo   = 1'b0;
        wait_idle(cyc);
        check("R4 busy cycles with move-to overlap", 32'(cyc), 32'(LAT));
        read_reg(1'b1, v);
        check("R6 start beats move-to HI", v, 32'd2);
        read_reg(1'b0, v);
        check("R6 start beats move-to LO", v, 32'd14);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule